// File: doc/BRIEF.md
# AUX Request Framer and Reply Parser

This block turns one DisplayPort AUX request into the byte sequence that the serial layer sends. It then reads back the reply bytes that the serial layer delivers and decodes them. A requester supplies a 4-bit command, a 20-bit address, a byte length and, for writes, the payload, and pulses `req_go`. The block streams the header and payload out over a valid/ready byte handshake and reports the total byte count.

After the last byte has gone out, the block collects the reply bytes until the serial layer marks the end of the reply. The first reply byte holds the reply status, and any bytes after it are read data. The block reports the reply code, the number of data bytes and the data itself, and it raises one of three error flags where a flag applies: an empty reply, a loss of hot-plug, or more data than the request asked for. A one-cycle `done` pulse marks the completion. The results stay on the outputs until the next completion.

The Manchester line coding is not part of this block. Both the transmit side and the receive side are byte-level handshakes.

Top module: `aux_req_framer`

## Requirements
- R1: Sent byte 0 is `{cmd[3:0], addr[19:16]}`.
- R2: Sent byte 1 is `addr[15:8]` and sent byte 2 is `addr[7:0]`.
- R3: When the length is nonzero, a fourth header byte equal to length−1 follows. When the length is zero, the header is three bytes.
- R4: For a write, the payload bytes follow the header in order. Byte k of the payload is `req_wdata[8k+7:8k]`. `tx_count` equals the header size plus the length for a write, and the header size alone for a read. It is valid from the cycle after the request is accepted.
- R5: A byte is consumed only in a cycle where both `tx_valid` and `tx_ready` are high. While `tx_ready` is low, `tx_byte` holds its value.
- R6: The reply code is bits 7:4 of the first received byte, and its lower nibble is ignored. When the code is 0 (ACK), `rd_data` holds the data bytes, with data byte j at bits 8j+7:8j and zeros in the unused bytes.
- R7: A reply that ends with zero received bytes sets `err_invalid`, and reports a reply code of 0 and a count of 0.
- R8: When at least one byte is received, `rd_count` equals the number of received bytes minus one, whatever the code. For a code other than 0, `rd_data` is all zero.
- R9: For an ACK whose data count exceeds the requested length, `err_overflow` is set and `rd_data` is all zero. `rd_count` still reports the count.
- R10: `hpd_lost` high in any busy cycle ends the transaction with `err_hpd` set and a code and count of 0. It takes priority over `rx_end` in the same cycle.
- R11: A `req_go` pulse is accepted only while the block is idle. While the block is busy, the pulse changes neither the request in progress nor `tx_count`.
- R12: `done` is high for exactly one cycle per transaction, and only one error flag is ever set. The results hold until the next completion.
- R13: A requested length above MAX_LEN (16) is treated as MAX_LEN.
- R14: A byte delivered in the same cycle as `rx_end` counts as part of the reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_go | input | 1 | Start strobe, used only when idle |
| req_cmd | input | 4 | Request command |
| req_addr | input | 20 | Request address |
| req_len | input | 5 | Byte length, 0 to 16 |
| req_write | input | 1 | High when the request carries a payload |
| req_wdata | input | 128 | Payload, byte k at bits 8k+7:8k |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Serial layer takes the byte |
| tx_byte | output | 8 | Transmit byte |
| tx_count | output | 5 | Total bytes of the current request |
| rx_valid | input | 1 | Received byte valid |
| rx_byte | input | 8 | Received byte |
| rx_end | input | 1 | End of reply |
| hpd_lost | input | 1 | Hot-plug lost |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| reply_code | output | 4 | Decoded reply code |
| rd_count | output | 6 | Data byte count (received minus one) |
| rd_data | output | 128 | Read data |
| err_invalid | output | 1 | Empty reply |
| err_hpd | output | 1 | Aborted by hot-plug loss |
| err_overflow | output | 1 | More data than requested |

## Verification
Hot-plug loss and end of reply can fall in the same cycle. The bench drives `hpd_lost` and `rx_end` together after two reply bytes and expects the abort outcome: `err_hpd` set, with a code and count of 0. A start request can also arrive while a transfer is stalled or waiting for its reply. The bench pulses `req_go` with different fields in both of those phases and confirms that `tx_count`, every sent byte and the overflow decision still follow the original request.

// File: rtl/aux_fr_pkg.sv
package aux_fr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } fr_state_e;
endpackage

// File: rtl/aux_fr_tx.sv
// Selects the transmit byte for a given stream index.
module aux_fr_tx #(
  parameter int MAX_LEN = 16,
  parameter int LW      = 5,
  parameter int TCW     = 5
) (
  input  logic [3:0]           cmd,
  input  logic [19:0]          addr,
  input  logic [LW-1:0]        len,
  input  logic [MAX_LEN*8-1:0] wdata,
  input  logic [TCW-1:0]       idx,
  output logic [7:0]           byte_o
);
  logic [TCW-1:0] hdr;
  logic [TCW-1:0] didx;

  always_comb begin
    hdr    = (len != '0) ? TCW'(4) : TCW'(3);
    didx   = idx - hdr;
    byte_o = 8'h00;
    if (idx == TCW'(0))                         byte_o = {cmd, addr[19:16]};
    else if (idx == TCW'(1))                    byte_o = addr[15:8];
    else if (idx == TCW'(2))                    byte_o = addr[7:0];
    else if (idx == TCW'(3) && len != '0)       byte_o = 8'(len) - 8'd1;
    else begin
      for (int k = 0; k < MAX_LEN; k++) begin
        if (didx == TCW'(k)) byte_o = wdata[k*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/aux_fr_rx.sv
// Collects reply bytes: status byte, data staging, saturating count.
module aux_fr_rx #(
  parameter int MAX_LEN = 16,
  parameter int RCW     = 6
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic                 clr,
  input  logic                 en,
  input  logic                 rx_valid,
  input  logic [7:0]           rx_byte,
  output logic [RCW-1:0]       cnt_eff,
  output logic [7:0]           status_eff,
  output logic [MAX_LEN*8-1:0] data_eff
);
  logic [RCW-1:0]       cnt_q;
  logic [7:0]           status_q;
  logic [MAX_LEN*8-1:0] stage_q;
  logic                 take;

  assign take = en & rx_valid;

  always_comb begin
    cnt_eff    = cnt_q;
    status_eff = status_q;
    data_eff   = stage_q;
    if (take) begin
      if (cnt_q != '1) cnt_eff = cnt_q + RCW'(1);
      if (cnt_q == '0) status_eff = rx_byte;
      for (int k = 0; k < MAX_LEN; k++) begin
        if (cnt_q == RCW'(k + 1)) data_eff[k*8 +: 8] = rx_byte;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      status_q <= '0;
      stage_q  <= '0;
    end else if (clr) begin
      cnt_q    <= '0;
      status_q <= '0;
      stage_q  <= '0;
    end else if (take) begin
      cnt_q    <= cnt_eff;
      status_q <= status_eff;
      stage_q  <= data_eff;
    end
  end
endmodule

// File: rtl/aux_req_framer.sv
module aux_req_framer #(
  parameter  int MAX_LEN = 16,
  localparam int LW      = $clog2(MAX_LEN + 1),
  localparam int TCW     = $clog2(MAX_LEN + 5),
  localparam int RCW     = $clog2(MAX_LEN + 2) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_go,
  input  logic [3:0]           req_cmd,
  input  logic [19:0]          req_addr,
  input  logic [LW-1:0]        req_len,
  input  logic                 req_write,
  input  logic [MAX_LEN*8-1:0] req_wdata,
  output logic                 tx_valid,
  input  logic                 tx_ready,
  output logic [7:0]           tx_byte,
  output logic [TCW-1:0]       tx_count,
  input  logic                 rx_valid,
  input  logic [7:0]           rx_byte,
  input  logic                 rx_end,
  input  logic                 hpd_lost,
  output logic                 busy,
  output logic                 done,
  output logic [3:0]           reply_code,
  output logic [RCW-1:0]       rd_count,
  output logic [MAX_LEN*8-1:0] rd_data,
  output logic                 err_invalid,
  output logic                 err_hpd,
  output logic                 err_overflow
);
  import aux_fr_pkg::*;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  fr_state_e            state_q, state_d;
  logic [TCW-1:0]       idx_q, idx_d, total_q, total_c, hdr_c;
  logic [3:0]           cmd_q;
  logic [19:0]          addr_q;
  logic [LW-1:0]        len_q, len_c;
  logic [MAX_LEN*8-1:0] wdata_q;

  logic                 accept, beat, last_beat, fin_hpd, fin_rx, fin;
  logic [RCW-1:0]       rx_cnt, dcnt;
  logic [7:0]           rx_status;
  logic [MAX_LEN*8-1:0] rx_data;
  logic                 rx_inv, rx_ovf;
  logic [3:0]           rcode;

  logic                 done_q;
  logic [3:0]           code_q, code_d;
  logic [RCW-1:0]       cnt_q, cnt_d;
  logic [MAX_LEN*8-1:0] data_q, data_d;
  logic                 inv_q, inv_d, hpd_q, hpd_d, ovf_q, ovf_d;

  // request capture values
  always_comb begin
    len_c   = (req_len > LW'(MAX_LEN)) ? LW'(MAX_LEN) : req_len;
    hdr_c   = (len_c != '0) ? TCW'(4) : TCW'(3);
    total_c = hdr_c + (req_write ? TCW'(len_c) : TCW'(0));
  end

  // sequencing
  always_comb begin
    accept    = (state_q == ST_IDLE) && req_go;
    beat      = (state_q == ST_SEND) && tx_ready;
    last_beat = beat && (idx_q == total_q - TCW'(1));
    fin_hpd   = (state_q != ST_IDLE) && hpd_lost;
    fin_rx    = (state_q == ST_WAIT) && rx_end && !hpd_lost;
    fin       = fin_hpd | fin_rx;
    state_d   = state_q;
    idx_d     = idx_q;
    case (state_q)
      ST_IDLE: if (accept) begin state_d = ST_SEND; idx_d = '0; end
      ST_SEND: begin
        if (fin_hpd)        state_d = ST_IDLE;
        else if (last_beat) state_d = ST_WAIT;
        if (beat) idx_d = idx_q + TCW'(1);
      end
      ST_WAIT: if (fin) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // reply decode
  always_comb begin
    rx_inv = (rx_cnt == '0);
    dcnt   = rx_cnt - RCW'(1);
    rcode  = rx_status[7:4];
    rx_ovf = !rx_inv && (rcode == 4'd0) && (dcnt > RCW'(len_q));
    if (fin_hpd) begin
      code_d = '0; cnt_d = '0; data_d = '0;
      inv_d  = 1'b0; hpd_d = 1'b1; ovf_d = 1'b0;
    end else begin
      code_d = rx_inv ? 4'd0 : rcode;
      cnt_d  = rx_inv ? '0 : dcnt;
      data_d = (!rx_inv && rcode == 4'd0 && !rx_ovf) ? rx_data : '0;
      inv_d  = rx_inv;
      hpd_d  = 1'b0;
      ovf_d  = rx_ovf;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      total_q <= '0;
      cmd_q   <= '0;
      addr_q  <= '0;
      len_q   <= '0;
      wdata_q <= '0;
      done_q  <= 1'b0;
      code_q  <= '0;
      cnt_q   <= '0;
      data_q  <= '0;
      inv_q   <= 1'b0;
      hpd_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      done_q  <= fin;
      if (accept) begin
        total_q <= total_c;
        cmd_q   <= req_cmd;
        addr_q  <= req_addr;
        len_q   <= len_c;
        wdata_q <= req_write ? req_wdata : '0;
      end
      if (fin) begin
        code_q <= code_d;
        cnt_q  <= cnt_d;
        data_q <= data_d;
        inv_q  <= inv_d;
        hpd_q  <= hpd_d;
        ovf_q  <= ovf_d;
      end
    end
  end

  aux_fr_tx #(.MAX_LEN(MAX_LEN), .LW(LW), .TCW(TCW)) u_tx (
    .cmd(cmd_q), .addr(addr_q), .len(len_q), .wdata(wdata_q),
    .idx(idx_q), .byte_o(tx_byte)
  );

  aux_fr_rx #(.MAX_LEN(MAX_LEN), .RCW(RCW)) u_rx (
    .clk(clk), .rst_ni(rst_ni), .clr(accept), .en(state_q == ST_WAIT),
    .rx_valid(rx_valid), .rx_byte(rx_byte),
    .cnt_eff(rx_cnt), .status_eff(rx_status), .data_eff(rx_data)
  );

  assign tx_valid     = (state_q == ST_SEND);
  assign tx_count     = total_q;
  assign busy         = (state_q != ST_IDLE);
  assign done         = done_q;
  assign reply_code   = code_q;
  assign rd_count     = cnt_q;
  assign rd_data      = data_q;
  assign err_invalid  = inv_q;
  assign err_hpd      = hpd_q;
  assign err_overflow = ovf_q;
endmodule

// File: rtl/aux_req_framer_chk.sv
module aux_req_framer_chk #(
  parameter  int MAX_LEN = 16,
  localparam int TCW     = $clog2(MAX_LEN + 5),
  localparam int RCW     = $clog2(MAX_LEN + 2) + 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_go,
  input logic                 busy,
  input logic                 done,
  input logic                 tx_valid,
  input logic                 tx_ready,
  input logic [7:0]           tx_byte,
  input logic [TCW-1:0]       tx_count,
  input logic                 hpd_lost,
  input logic [3:0]           reply_code,
  input logic [RCW-1:0]       rd_count,
  input logic [MAX_LEN*8-1:0] rd_data,
  input logic                 err_invalid,
  input logic                 err_hpd,
  input logic                 err_overflow
);
  // R5
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !hpd_lost |=> tx_valid && $stable(tx_byte));
  // R7
  invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && err_invalid |-> rd_count == '0 && reply_code == 4'd0);
  // R9
  overflow_nodata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && err_overflow |-> rd_data == '0);
  // R10
  hpd_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && hpd_lost |=> done && err_hpd && !busy);
  // R11
  busy_go_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && req_go |=> $stable(tx_count));
  // R11
  idle_go_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && req_go |=> busy);
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R12
  one_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_invalid, err_hpd, err_overflow}));
  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !tx_valid);
endmodule

bind aux_req_framer aux_req_framer_chk #(.MAX_LEN(MAX_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_go(req_go), .busy(busy), .done(done),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte),
  .tx_count(tx_count), .hpd_lost(hpd_lost), .reply_code(reply_code),
  .rd_count(rd_count), .rd_data(rd_data), .err_invalid(err_invalid),
  .err_hpd(err_hpd), .err_overflow(err_overflow)
);

// File: tb/aux_req_framer_tb.sv
`timescale 1ns/100ps
module aux_req_framer_tb_top;
  localparam int MAX_LEN = 16;
  localparam int LW = 5, TCW = 5, RCW = 6;

  logic clk = 1'b0;
  logic rst_n, req_go, req_write, tx_ready, rx_valid, rx_end, hpd_lost;
  logic [3:0] req_cmd;
  logic [19:0] req_addr;
  logic [LW-1:0] req_len;
  logic [MAX_LEN*8-1:0] req_wdata;
  logic tx_valid, busy, done, err_invalid, err_hpd, err_overflow;
  logic [7:0] tx_byte, rx_byte;
  logic [TCW-1:0] tx_count;
  logic [3:0] reply_code;
  logic [RCW-1:0] rd_count;
  logic [MAX_LEN*8-1:0] rd_data;

  int n_cmp = 0, n_bad = 0;
  logic [3:0] cur_cmd;
  logic [19:0] cur_addr;
  int cur_len, cur_wr, cur_seed;

  always #2.5 clk = ~clk;

  aux_req_framer #(.MAX_LEN(MAX_LEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_go(req_go), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_len(req_len), .req_write(req_write),
    .req_wdata(req_wdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_byte(tx_byte), .tx_count(tx_count), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rx_end(rx_end), .hpd_lost(hpd_lost), .busy(busy),
    .done(done), .reply_code(reply_code), .rd_count(rd_count),
    .rd_data(rd_data), .err_invalid(err_invalid), .err_hpd(err_hpd),
    .err_overflow(err_overflow)
  );

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] wbyte(int seed, int i);
    return 8'((seed * 37 + i * 11 + 3) ^ 8'h5A);
  endfunction

  function automatic logic [7:0] rbyte(int seed, int i);
    return 8'(seed * 29 + i * 5 + 1);
  endfunction

  function automatic logic [7:0] exp_tx(int k);
    int h;
    h = (cur_len != 0) ? 4 : 3;
    if (k == 0) return {cur_cmd, cur_addr[19:16]};
    if (k == 1) return cur_addr[15:8];
    if (k == 2) return cur_addr[7:0];
    if (k == 3 && cur_len != 0) return 8'(cur_len - 1);
    return wbyte(cur_seed, k - h);
  endfunction

  task automatic start_req(logic [3:0] cmd, logic [19:0] addr, int len, int wr, int seed);
    int tot;
    cur_cmd = cmd; cur_addr = addr; cur_wr = wr; cur_seed = seed;
    cur_len = (len > MAX_LEN) ? MAX_LEN : len;   // R13
    req_cmd = cmd; req_addr = addr; req_len = LW'(len); req_write = wr[0];
    for (int i = 0; i < MAX_LEN; i++) req_wdata[i*8 +: 8] = wbyte(seed, i);
    req_go = 1'b1;
    @(negedge clk);
    req_go = 1'b0;
    tot = ((cur_len != 0) ? 4 : 3) + (wr != 0 ? cur_len : 0);
    chk("R4 tx_count", 128'(tx_count), 128'(tot));
    chk("R11 accepted when idle", 128'({busy, tx_valid}), 128'(2'b11));
  endtask

  task automatic collect(int rmode);
    int tot, k, cyc;
    string tag;
    tot = ((cur_len != 0) ? 4 : 3) + (cur_wr != 0 ? cur_len : 0);
    k = 0; cyc = 0;
    while (k < tot && cyc < 200) begin
      tx_ready = (rmode == 0) ? 1'b1 : ((cyc % 3) != 1);
      #1;
      if (tx_valid && tx_ready) begin
        if (k == 0) tag = "R1 byte0";
        else if (k < 3) tag = "R2 addr byte";
        else if (k == 3 && cur_len != 0) tag = "R3 length byte";
        else tag = "R4 payload byte";
        if (rmode != 0) tag = {tag, " R5"};
        chk(tag, 128'(tx_byte), 128'(exp_tx(k)));
        k++;
      end
      @(negedge clk);
      cyc++;
    end
    tx_ready = 1'b1;
    chk("R4 stream ends after count", 128'({k == tot, tx_valid, busy}), 128'(3'b101));
  endtask

  task automatic do_reply(int n, logic [3:0] code, int seed, int endlast);
    logic [127:0] ed;
    int dc, ovf, inv;
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1;
      rx_byte  = (i == 0) ? {code, 4'h6} : rbyte(seed, i - 1);
      rx_end   = (endlast != 0 && i == n - 1);
      @(negedge clk);
    end
    if (!(endlast != 0 && n > 0)) begin
      rx_valid = 1'b0; rx_end = 1'b1;
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_end = 1'b0;
    inv = (n == 0);
    dc  = inv ? 0 : n - 1;
    ovf = !inv && code == 4'd0 && dc > cur_len;
    ed  = '0;
    if (!inv && code == 4'd0 && !ovf)
      for (int j = 0; j < dc; j++) ed[j*8 +: 8] = rbyte(seed, j);
    chk("R12 done pulse", 128'({done, busy}), 128'(2'b10));
    chk(inv ? "R7 invalid flag" : "R9 overflow flag",
        128'({err_invalid, err_overflow, err_hpd}), 128'({inv[0], ovf[0], 1'b0}));
    chk("R6 reply code", 128'(reply_code), 128'(inv ? 4'd0 : code));
    chk("R8 data count", 128'(rd_count), 128'(dc));
    chk("R6 read data", rd_data, ed);
    @(negedge clk);
    chk("R12 done low and results held", 128'({done, rd_count}), 128'({1'b0, 6'(dc)}));
  endtask

  initial begin
    rst_n = 1'b0; req_go = 0; req_write = 0; tx_ready = 1; rx_valid = 0;
    rx_end = 0; hpd_lost = 0; req_cmd = 0; req_addr = 0; req_len = 0;
    req_wdata = '0; rx_byte = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 reset outputs", 128'({busy, done, tx_valid, err_invalid, err_hpd, err_overflow, rd_count}), 128'(0));

    // sweep of lengths, directions and backpressure
    for (int len = 0; len <= 19; len++) begin
      for (int wr = 0; wr < 2; wr++) begin
        int l;
        l = (len == 19) ? 31 : len;
        start_req(4'(l + wr * 3), 20'h12345 ^ 20'(l * 20'h0F0F1), l, wr, l * 2 + wr);
        collect((l + wr) % 2);
        if (wr != 0) do_reply(1, 4'd0, l, 0);
        else do_reply(((l > MAX_LEN) ? MAX_LEN : l) + 1, 4'd0, l + 7, l % 3 == 0);
      end
    end

    // R8 non-ACK codes
    start_req(4'h9, 20'hABCDE, 4, 0, 3); collect(0); do_reply(3, 4'd1, 5, 0);
    start_req(4'h9, 20'h00001, 4, 0, 4); collect(0); do_reply(1, 4'd2, 6, 0);
    // R7 empty reply
    start_req(4'h9, 20'hFFFFF, 2, 0, 5); collect(0); do_reply(0, 4'd0, 0, 0);
    // R9 overflow
    start_req(4'h9, 20'h54321, 2, 0, 6); collect(1); do_reply(5, 4'd0, 8, 0);
    start_req(4'h9, 20'h00100, 0, 0, 7); collect(0); do_reply(2, 4'd0, 9, 0);
    // R14 byte on the rx_end cycle
    start_req(4'h9, 20'h0A0A0, 3, 0, 8); collect(0); do_reply(4, 4'd0, 10, 1);

    // R10 abort during transmit
    start_req(4'h8, 20'h11111, 6, 1, 9);
    hpd_lost = 1'b1;
    @(negedge clk);
    hpd_lost = 1'b0;
    chk("R10 abort in send", 128'({done, err_hpd, err_invalid, err_overflow, busy, tx_valid}), 128'(6'b110000));
    chk("R10 code and count zero", 128'({reply_code, rd_count}), 128'(0));

    // R10 hot-plug loss and rx_end in the same cycle
    start_req(4'h9, 20'h22222, 3, 0, 10); collect(0);
    for (int i = 0; i < 2; i++) begin
      rx_valid = 1'b1; rx_byte = (i == 0) ? 8'h00 : 8'h77;
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_end = 1'b1; hpd_lost = 1'b1;
    @(negedge clk);
    rx_end = 1'b0; hpd_lost = 1'b0;
    chk("R10 hpd wins over rx_end", 128'({done, err_hpd, err_invalid, err_overflow}), 128'(4'b1100));
    chk("R10 nothing reported", 128'({reply_code, rd_count, rd_data}), 128'(0));

    // R11 go while stalled in transmit and while waiting
    tx_ready = 1'b0;
    start_req(4'h9, 20'h33333, 4, 0, 11);
    req_cmd = 4'h1; req_addr = 20'h44444; req_len = 5'd10; req_write = 1'b1; req_go = 1'b1;
    @(negedge clk);
    req_go = 1'b0;
    chk("R11 busy go ignored count", 128'({busy, tx_count}), 128'({1'b1, 5'd4}));
    collect(0);
    req_len = 5'd16; req_go = 1'b1;
    @(negedge clk);
    req_go = 1'b0;
    chk("R11 go ignored in wait", 128'({busy, tx_valid, tx_count}), 128'({2'b10, 5'd4}));
    do_reply(5, 4'd0, 12, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R12 watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule